// File: doc/BRIEF.md
# Binary-Weighted Multi-Pin Intensity Modulator

This block sets the brightness of many output pins, for example the red, green and blue channels of eight tricolor LED banks, using bit-angle modulation. Each frame is cut into a fixed number of slots, and each slot is twice as long as the one before it. Every slot has a full pattern word that holds the level of every pin for the whole slot. A pin's on-time per frame is therefore the weighted sum of its pattern bits. So one pattern bit plane per slot sets all the intensities at once, with no per-pin counters.

Frames run back to back at an exact period, counted in clocks. Software, or an upstream engine that computes the intensity curves, fills a staging bank of patterns through a simple write port and then requests a commit. The staged bank replaces the live one only at a frame boundary, so a frame never shows a mix of old and new patterns. A one-clock frame marker lets other logic lock onto the frame.

Top module: `bam_modulator`

## Requirements
- R1: After reset the live bank holds all zeros, so enabling the block without any commit keeps every pin low. The frame marker still pulses.
- R2: A frame has SLOTS slots, played in the order slot 0, 1, ... SLOTS-1. Slot k lasts UNIT_CLKS * 2^k clocks.
- R3: A frame lasts exactly UNIT_CLKS * (2^SLOTS - 1) clocks. While enable stays high, frames follow each other with no gap.
- R4: During slot k, pins_o equals the live pattern of slot k for every clock of that slot. Bit i of the pattern drives pins_o[i], and a 1 means high.
- R5: Over one frame, pin i is high for exactly UNIT_CLKS * sum over k of (bit i of pattern k) * 2^k clocks.
- R6: frame_start_o is high for exactly one clock, the first clock of slot 0 of each frame.
- R7: While enable is low, pins_o is all zero, frame_start_o is low and the sequencer is held at the start of slot 0. The first clock with enable high is the first clock of a new frame, even if enable dropped in the middle of a frame.
- R8: A write (wr_en, with wr_slot selecting the slot and wr_data the pattern) changes only the staging bank and has no effect on pins_o until a commit. A commit applies the whole staging bank from the next frame start, never in the middle of a frame.
- R9: A commit made while enable is low is applied before the next frame begins. The first frame after enable then uses the new patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the frame sequencer; low forces dark outputs |
| wr_en | input | 1 | Write one staging pattern this cycle |
| wr_slot | input | $clog2(SLOTS) | Slot index of the pattern being written |
| wr_data | input | PINS | Pattern word for that slot |
| commit | input | 1 | Request that the staging bank go live at the next frame start |
| pins_o | output | PINS | Modulated pin levels |
| frame_start_o | output | 1 | One-clock marker at the first clock of each frame |

## Verification
On every cycle the checker verifies several properties. Outputs stay dark and the sequencer restarts cleanly when disabled. The frame marker is a single clock, and frame markers are exactly one frame length apart. Slots advance only in ascending order with wrap, pins hold steady inside a slot, and no commit is left pending at a frame start. The properties cannot show which pattern appears in which slot, the per-pin on-time sums, or whether staged writes without a commit stay invisible. Those depend on the stored data, so only the bench scenarios, compared against an arithmetic model over many pattern sets, can demonstrate them.

// File: rtl/bam_pkg.sv
package bam_pkg;
   // Clocks in one full frame: sum of UNIT * 2^k for k in [0, SLOTS)
   function automatic int unsigned frame_clks(input int unsigned slots, input int unsigned unit);
      return unit * ((32'd1 << slots) - 32'd1);
   endfunction
endpackage

// File: rtl/bam_timebase.sv
module bam_timebase #(
   parameter int unsigned SLOTS     = 16,
   parameter int unsigned UNIT_CLKS = 1,
   localparam int unsigned SLOT_W   = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic [SLOT_W-1:0] slot_o,
   output logic              first_o,
   output logic              last_o
);
   logic [SLOT_W-1:0] slot_q;
   logic [SLOTS-1:0]  dwell_q;
   logic [SLOTS-1:0]  dwell_lim;
   logic              tick;
   logic              unit_zero;
   logic              slot_end;
   logic              last_slot;

   // Prescaler variant chosen by the base unit
   generate
      if (UNIT_CLKS == 1) begin : g_no_pre
         assign tick      = 1'b1;
         assign unit_zero = 1'b1;
      end else begin : g_pre
         localparam int unsigned PRE_W = $clog2(UNIT_CLKS);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)        pre_q <= '0;
            else if (tick)             pre_q <= '0;
            else                       pre_q <= pre_q + 1'b1;
         end
         assign tick      = (pre_q == PRE_W'(UNIT_CLKS - 1));
         assign unit_zero = (pre_q == '0);
      end
   endgenerate

   // Slot k holds for 2^k units: limit is a mask of k low ones
   always_comb begin
      dwell_lim = '0;
      for (int i = 0; i < SLOTS; i++)
         if (SLOT_W'(i) < slot_q) dwell_lim[i] = 1'b1;
   end

   assign slot_end  = tick && (dwell_q == dwell_lim);
   assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         slot_q  <= '0;
         dwell_q <= '0;
      end else if (slot_end) begin
         dwell_q <= '0;
         slot_q  <= last_slot ? '0 : slot_q + 1'b1;
      end else if (tick) begin
         dwell_q <= dwell_q + 1'b1;
      end
   end

   assign slot_o  = slot_q;
   assign first_o = run && unit_zero && (dwell_q == '0) && (slot_q == '0);
   assign last_o  = run && slot_end && last_slot;
endmodule

// File: rtl/bam_bank.sv
module bam_bank #(
   parameter int unsigned PINS  = 24,
   parameter int unsigned SLOTS = 16,
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [PINS-1:0]   wr_data,
   input  logic              commit,
   input  logic              swap_ok,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [PINS-1:0]   rd_data,
   output logic              pending_o
);
   logic [PINS-1:0] stage_q [SLOTS];
   logic [PINS-1:0] live_q  [SLOTS];
   logic            pend_q;
   logic            do_swap;

   assign do_swap = pend_q && swap_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SLOTS; k++) begin
            stage_q[k] <= '0;
            live_q[k]  <= '0;
         end
      end else begin
         if (wr_en && (int'(wr_slot) < SLOTS)) stage_q[wr_slot] <= wr_data;
         if (do_swap)
            for (int k = 0; k < SLOTS; k++) live_q[k] <= stage_q[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (commit)  pend_q <= 1'b1;
      else if (do_swap) pend_q <= 1'b0;
   end

   assign rd_data   = live_q[rd_slot];
   assign pending_o = pend_q;
endmodule

// File: rtl/bam_modulator.sv
module bam_modulator #(
   parameter int unsigned PINS      = 24,
   parameter int unsigned SLOTS     = 16,
   parameter int unsigned UNIT_CLKS = 1,
   localparam int unsigned SLOT_W   = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [PINS-1:0]   wr_data,
   input  logic              commit,
   output logic [PINS-1:0]   pins_o,
   output logic              frame_start_o
);
   generate
      if (PINS < 1)        begin : g_bad_pins  $error("PINS must be at least 1");       end
      if (SLOTS < 2)       begin : g_bad_slots $error("SLOTS must be at least 2");      end
      if (SLOTS > 24)      begin : g_big_slots $error("SLOTS above 24 is not allowed"); end
      if (UNIT_CLKS < 1)   begin : g_bad_unit  $error("UNIT_CLKS must be at least 1");  end
   endgenerate

   logic [SLOT_W-1:0] slot_w;
   logic              first_w;
   logic              last_w;
   logic [PINS-1:0]   pat_w;
   logic              pend_w;

   bam_timebase #(.SLOTS(SLOTS), .UNIT_CLKS(UNIT_CLKS)) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (enable),
      .slot_o  (slot_w),
      .first_o (first_w),
      .last_o  (last_w)
   );

   bam_bank #(.PINS(PINS), .SLOTS(SLOTS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_slot   (wr_slot),
      .wr_data   (wr_data),
      .commit    (commit),
      .swap_ok   (!enable || last_w),
      .rd_slot   (slot_w),
      .rd_data   (pat_w),
      .pending_o (pend_w)
   );

   assign pins_o        = enable ? pat_w : '0;
   assign frame_start_o = first_w;
endmodule

// File: rtl/bam_modulator_chk.sv
module bam_modulator_chk #(
   parameter int unsigned PINS      = 24,
   parameter int unsigned SLOTS     = 16,
   parameter int unsigned UNIT_CLKS = 1,
   localparam int unsigned SLOT_W   = $clog2(SLOTS),
   localparam int unsigned FRAME    = bam_pkg::frame_clks(SLOTS, UNIT_CLKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              commit,
   input logic [PINS-1:0]   pins_o,
   input logic              frame_start_o,
   input logic [SLOT_W-1:0] slot_idx,
   input logic              pending
);
   logic [31:0] since_q;
   logic        seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (frame_start_o) begin
         since_q <= 32'd1;
         seen_q  <= 1'b1;
      end else begin
         since_q <= since_q + 32'd1;
      end
   end

   p_dark_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (pins_o == '0) && !frame_start_o);

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      enable && !$past(enable) |-> frame_start_o && (slot_idx == '0));

   p_one_clock_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> !frame_start_o);

   p_frame_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o && seen_q |-> since_q == 32'(FRAME));

   p_frame_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
      enable && seen_q && (since_q == 32'(FRAME)) |-> frame_start_o);

   p_slot_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      enable && $past(enable) && (slot_idx != $past(slot_idx)) |->
         (slot_idx == $past(slot_idx) + 1'b1) ||
         ((slot_idx == '0) && ($past(slot_idx) == SLOT_W'(SLOTS - 1))));

   p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      enable && $past(enable) && $stable(slot_idx) |-> $stable(pins_o));

   p_swap_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o && !$past(commit) |-> !pending);
endmodule

bind bam_modulator bam_modulator_chk #(.PINS(PINS), .SLOTS(SLOTS), .UNIT_CLKS(UNIT_CLKS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .commit        (commit),
   .pins_o        (pins_o),
   .frame_start_o (frame_start_o),
   .slot_idx      (slot_w),
   .pending       (pend_w)
);

// File: tb/sim_bam_modulator.sv
`timescale 1ns/1ps
module sim_bam_modulator;
   localparam int PINS   = 6;
   localparam int SLOTS  = 4;
   localparam int UNIT   = 2;
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int FRAME  = UNIT * ((1 << SLOTS) - 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic              wr_en = 1'b0;
   logic [SLOT_W-1:0] wr_slot = '0;
   logic [PINS-1:0]   wr_data = '0;
   logic              commit = 1'b0;
   logic [PINS-1:0]   pins_o;
   logic              frame_start_o;

   always #10 clk = ~clk;

   bam_modulator #(.PINS(PINS), .SLOTS(SLOTS), .UNIT_CLKS(UNIT)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_data(wr_data), .commit(commit), .pins_o(pins_o), .frame_start_o(frame_start_o)
   );

   int checks = 0;
   int failures = 0;
   logic [PINS-1:0] cur [SLOTS];
   logic [PINS-1:0] stg [SLOTS];
   bit pend = 0;
   int t = 0;
   int on_cnt [PINS];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int slot_of(input int u);
      for (int k = 0; k < SLOTS; k++)
         if (u < UNIT * ((1 << (k + 1)) - 1)) return k;
      return SLOTS - 1;
   endfunction

   // One clock: drive at negedge, sample 1 ns later, then advance
   task automatic cycle(input logic en, input logic we, input int ws,
                        input logic [PINS-1:0] wd, input logic cm);
      enable = en; wr_en = we; wr_slot = SLOT_W'(ws); wr_data = wd; commit = cm;
      #1;
      if (!en) begin
         chk("R7 dark pins", 32'(pins_o), 32'd0);
         chk("R7 no marker", 32'(frame_start_o), 32'd0);
         t = 0;
         for (int i = 0; i < PINS; i++) on_cnt[i] = 0;
      end else begin
         int u;
         u = t % FRAME;
         if (u == 0 && pend) begin
            for (int k = 0; k < SLOTS; k++) cur[k] = stg[k];
            pend = 0;
         end
         chk("R6 marker", 32'(frame_start_o), (u == 0) ? 32'd1 : 32'd0);
         chk("R4 R2 slot pattern", 32'(pins_o), 32'(cur[slot_of(u)]));
         for (int i = 0; i < PINS; i++) on_cnt[i] += int'(pins_o[i]);
         if (u == FRAME - 1) begin
            for (int i = 0; i < PINS; i++) begin
               int e;
               e = 0;
               for (int k = 0; k < SLOTS; k++) if (cur[k][i]) e += UNIT << k;
               chk("R5 on-time", 32'(on_cnt[i]), 32'(e));
               on_cnt[i] = 0;
            end
         end
         t++;
      end
      if (we) stg[ws] = wd;
      if (cm) pend = 1;
      @(negedge clk);
   endtask

   task automatic run(input logic en, input int n);
      for (int c = 0; c < n; c++) cycle(en, 1'b0, 0, '0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int k = 0; k < SLOTS; k++) begin cur[k] = '0; stg[k] = '0; end
      for (int i = 0; i < PINS; i++) on_cnt[i] = 0;
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
         #1;
         chk("R1 reset pins", 32'(pins_o), 32'd0);
         chk("R1 reset marker", 32'(frame_start_o), 32'd0);
         @(negedge clk);
      end
      rst_n = 1'b1;
      run(1'b0, 3);
      // R1: no commit yet, live bank blank
      run(1'b1, 2 * FRAME);
      // R8: staged writes and a commit in mid-frame; applied at next frame start (R3 continuity)
      for (int k = 0; k < SLOTS; k++) cycle(1'b1, 1'b1, k, PINS'(6'h15 + 7 * k), 1'b0);
      cycle(1'b1, 1'b0, 0, '0, 1'b1);
      run(1'b1, 3 * FRAME);
      // R8: writes without commit stay invisible
      for (int k = 0; k < SLOTS; k++) cycle(1'b1, 1'b1, k, PINS'(6'h2A ^ (k * 9)), 1'b0);
      run(1'b1, 2 * FRAME + 7);
      // R7 disable mid-frame, R9 commit while idle
      run(1'b0, 4);
      cycle(1'b0, 1'b0, 0, '0, 1'b1);
      run(1'b0, 2);
      run(1'b1, 2 * FRAME + 11);
      // R7 re-enable mid-frame restarts at slot 0
      run(1'b0, 1);
      run(1'b1, FRAME + 3);
      run(1'b0, 2);
      // Sweep of pattern sets: walking ones, all ones, arithmetic mixes
      for (int s = 0; s < 24; s++) begin
         for (int k = 0; k < SLOTS; k++) begin
            logic [PINS-1:0] p;
            if (s < PINS)       p = PINS'(1 << ((s + k) % PINS));
            else if (s == PINS) p = '1;
            else                p = PINS'(s * 37 + k * 11 + (s >> 1) * k);
            cycle(1'b0, 1'b1, k, p, 1'b0);
         end
         cycle(1'b0, 1'b0, 0, '0, 1'b1);
         run(1'b0, 1);
         run(1'b1, 2 * FRAME);
         run(1'b0, 1);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule